// File: doc/BRIEF.md
# Residence Time Correction Updater

This block sits on the path of a timing event message through a switch that acts as a transparent timing node. Each message arrives with a 4-bit type code, the local time at which it entered the node, the local time at which it leaves, and the correction value it already carries. The block measures the residence time as egress time minus ingress time. For the two event types whose timing matters, it adds that residence time to the correction. It sends every other message on with its correction unchanged. The block never touches an origin or receive timestamp, because those never pass through it.

Corrections are signed two's-complement values in nanoseconds with FRAC_BITS fraction bits. Timestamps are unsigned whole nanoseconds, so the block shifts the residence left by FRAC_BITS before the add. The datapath is a two-stage pipeline with no stalls: it accepts a new message on every clock, and each result appears a fixed number of cycles later. If an event message claims to leave before it arrived, the block forwards its correction unchanged and marks the result with an error flag.

Top module: `tc_corr_updater`

## Requirements
- R1: While `rst` is high, and on the first cycles after it falls, `out_valid` and `err_out` are low.
- R2: For type code 0 (sync) with `egress_ts >= ingress_ts`, `corr_out` equals `corr_in + ((egress_ts - ingress_ts) << FRAC_BITS)`.
- R3: For type code 1 (delay request) with `egress_ts >= ingress_ts`, `corr_out` equals `corr_in + ((egress_ts - ingress_ts) << FRAC_BITS)`.
- R4: For type code 8 (follow-up), `corr_out` equals `corr_in` and `err_out` stays low, whatever the timestamps are.
- R5: For type code 9 (delay response), `corr_out` equals `corr_in` and `err_out` stays low, whatever the timestamps are.
- R6: For any code other than 0, 1, 8 and 9, `corr_out` equals `corr_in` and `err_out` stays low.
- R7: For codes 0 and 1 with `egress_ts < ingress_ts`, `corr_out` equals `corr_in` and `err_out` is high for that result. Equal timestamps give zero residence and no error.
- R8: A message sampled with `in_valid` high at a rising edge produces `out_valid` high for exactly one cycle, starting two rising edges later. Messages may arrive on consecutive cycles.
- R9: `out_type` repeats the type code of the message whose result is being presented.
- R10: While `out_valid` is low, `corr_out`, `out_type` and `err_out` are all zero.
- R11: The addition wraps modulo 2^CORR_W, so a sum past the largest positive correction wraps to a negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message present, egress time known |
| msg_type | input | 4 | Message type code |
| ingress_ts | input | TS_W | Ingress time, ns |
| egress_ts | input | TS_W | Egress time, ns |
| corr_in | input | CORR_W | Incoming correction, scaled ns |
| out_valid | output | 1 | Result strobe |
| out_type | output | 4 | Type code of the result |
| corr_out | output | CORR_W | Updated correction |
| err_out | output | 1 | Egress earlier than ingress on an event message |

## Verification
The bench builds the block with TS_W set to 32, while CORR_W stays at 64 and FRAC_BITS stays at 16. With 32-bit timestamps, random ingress and egress values often land with egress below ingress, which exercises the error path. With 32-bit timestamps, the largest shifted residence still fits in the correction, so every carry and wrap comes from the correction add alone. Directed cases cover equal timestamps, a residence of one nanosecond, the largest residence, and a correction close to the signed maximum.

// File: rtl/tc_corr_pkg.sv
package tc_corr_pkg;

    localparam logic [3:0] MT_SYNC  = 4'h0;
    localparam logic [3:0] MT_DREQ  = 4'h1;
    localparam logic [3:0] MT_FUP   = 4'h8;
    localparam logic [3:0] MT_DRESP = 4'h9;

    typedef enum logic {
        ACT_PASS = 1'b0,
        ACT_ADD  = 1'b1
    } corr_act_e;

    typedef struct packed {
        logic      valid;
        logic [3:0] mtype;
        corr_act_e act;
        logic      late;
    } stage_ctl_t;

    // Only the two event types accumulate residence; everything else passes.
    function automatic corr_act_e classify(input logic [3:0] code);
        case (code)
            MT_SYNC, MT_DREQ: return ACT_ADD;
            default:          return ACT_PASS;
        endcase
    endfunction

endpackage

// File: rtl/tc_resid_stage.sv
module tc_resid_stage
    import tc_corr_pkg::*;
#(
    parameter int TS_W   = 48,
    parameter int CORR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        msg_type,
    input  logic [TS_W-1:0]   ingress_ts,
    input  logic [TS_W-1:0]   egress_ts,
    input  logic [CORR_W-1:0] corr_in,
    output stage_ctl_t        ctl_q,
    output logic [TS_W-1:0]   resid_q,
    output logic [CORR_W-1:0] corr_q
);

    stage_ctl_t      ctl_d;
    logic [TS_W-1:0] resid_d;

    always_comb begin
        ctl_d.valid = in_valid;
        ctl_d.mtype = msg_type;
        ctl_d.act   = classify(msg_type);
        ctl_d.late  = (egress_ts < ingress_ts);
        resid_d     = egress_ts - ingress_ts;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            resid_q <= '0;
            corr_q  <= '0;
        end else begin
            ctl_q   <= ctl_d;
            resid_q <= resid_d;
            corr_q  <= corr_in;
        end
    end

endmodule

// File: rtl/tc_corr_add_stage.sv
module tc_corr_add_stage
    import tc_corr_pkg::*;
#(
    parameter int TS_W      = 48,
    parameter int CORR_W    = 64,
    parameter int FRAC_BITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  stage_ctl_t        ctl,
    input  logic [TS_W-1:0]   resid,
    input  logic [CORR_W-1:0] corr,
    output logic              out_valid,
    output logic [3:0]        out_type,
    output logic [CORR_W-1:0] corr_out,
    output logic              err_out
);

    logic [CORR_W-1:0] scaled;
    logic [CORR_W-1:0] sum;
    logic              do_add;
    logic              bad;

    always_comb begin
        scaled = CORR_W'(resid) << FRAC_BITS;
        sum    = corr + scaled;
        do_add = (ctl.act == ACT_ADD) && !ctl.late;
        bad    = (ctl.act == ACT_ADD) && ctl.late;
    end

    always_ff @(posedge clk) begin
        if (rst || !ctl.valid) begin
            out_valid <= 1'b0;
            out_type  <= '0;
            corr_out  <= '0;
            err_out   <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            out_type  <= ctl.mtype;
            corr_out  <= do_add ? sum : corr;
            err_out   <= bad;
        end
    end

endmodule

// File: rtl/tc_corr_updater.sv
module tc_corr_updater
    import tc_corr_pkg::*;
#(
    parameter int TS_W      = 48,
    parameter int CORR_W    = 64,
    parameter int FRAC_BITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        msg_type,
    input  logic [TS_W-1:0]   ingress_ts,
    input  logic [TS_W-1:0]   egress_ts,
    input  logic [CORR_W-1:0] corr_in,
    output logic              out_valid,
    output logic [3:0]        out_type,
    output logic [CORR_W-1:0] corr_out,
    output logic              err_out
);

    stage_ctl_t        s1_ctl;
    logic [TS_W-1:0]   s1_resid;
    logic [CORR_W-1:0] s1_corr;

    tc_resid_stage #(
        .TS_W   (TS_W),
        .CORR_W (CORR_W)
    ) u_resid (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .msg_type   (msg_type),
        .ingress_ts (ingress_ts),
        .egress_ts  (egress_ts),
        .corr_in    (corr_in),
        .ctl_q      (s1_ctl),
        .resid_q    (s1_resid),
        .corr_q     (s1_corr)
    );

    tc_corr_add_stage #(
        .TS_W      (TS_W),
        .CORR_W    (CORR_W),
        .FRAC_BITS (FRAC_BITS)
    ) u_add (
        .clk       (clk),
        .rst       (rst),
        .ctl       (s1_ctl),
        .resid     (s1_resid),
        .corr      (s1_corr),
        .out_valid (out_valid),
        .out_type  (out_type),
        .corr_out  (corr_out),
        .err_out   (err_out)
    );

endmodule

// File: rtl/tc_corr_updater_chk.sv
module tc_corr_updater_chk #(
    parameter int TS_W      = 48,
    parameter int CORR_W    = 64,
    parameter int FRAC_BITS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [3:0]        msg_type,
    input logic [TS_W-1:0]   ingress_ts,
    input logic [TS_W-1:0]   egress_ts,
    input logic [CORR_W-1:0] corr_in,
    input logic              out_valid,
    input logic [3:0]        out_type,
    input logic [CORR_W-1:0] corr_out,
    input logic              err_out
);

    logic [1:0] since_rst;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
    assign warm = (since_rst >= 2'd2);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !err_out));

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 2)));

    assert_type_echo_R9: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |-> (out_type == $past(msg_type, 2)));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (corr_out == '0 && out_type == '0 && !err_out));

    assert_err_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
        err_out |-> (out_valid && (out_type == 4'h0 || out_type == 4'h1)));

    assert_err_keeps_corr_R7: assert property (@(posedge clk) disable iff (rst)
        (warm && err_out) |-> (corr_out == $past(corr_in, 2)));

    assert_followup_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && out_type == 4'h8) |-> (corr_out == $past(corr_in, 2) && !err_out));

    assert_dresp_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && out_type == 4'h9) |-> (corr_out == $past(corr_in, 2) && !err_out));

    assert_sync_add_R2: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && out_type == 4'h0 && !err_out) |->
        (corr_out == $past(corr_in, 2)
            + (CORR_W'($past(egress_ts, 2) - $past(ingress_ts, 2)) << FRAC_BITS)));

endmodule

bind tc_corr_updater tc_corr_updater_chk #(
    .TS_W      (TS_W),
    .CORR_W    (CORR_W),
    .FRAC_BITS (FRAC_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .msg_type   (msg_type),
    .ingress_ts (ingress_ts),
    .egress_ts  (egress_ts),
    .corr_in    (corr_in),
    .out_valid  (out_valid),
    .out_type   (out_type),
    .corr_out   (corr_out),
    .err_out    (err_out)
);

// File: tb/tb_tc_corr_updater.sv
module tb_tc_corr_updater;

    localparam int TS_W      = 32;
    localparam int CORR_W    = 64;
    localparam int FRAC_BITS = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [3:0]        msg_type = '0;
    logic [TS_W-1:0]   ingress_ts = '0;
    logic [TS_W-1:0]   egress_ts = '0;
    logic [CORR_W-1:0] corr_in = '0;
    logic              out_valid;
    logic [3:0]        out_type;
    logic [CORR_W-1:0] corr_out;
    logic              err_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expectation pipeline: index 0 = driven last negedge, 1 = two negedges ago
    logic              e_v   [2];
    logic [3:0]        e_t   [2];
    logic [CORR_W-1:0] e_c   [2];
    logic              e_err [2];
    string             e_tag [2];

    always #5 clk = ~clk;

    tc_corr_updater #(
        .TS_W      (TS_W),
        .CORR_W    (CORR_W),
        .FRAC_BITS (FRAC_BITS)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .msg_type   (msg_type),
        .ingress_ts (ingress_ts),
        .egress_ts  (egress_ts),
        .corr_in    (corr_in),
        .out_valid  (out_valid),
        .out_type   (out_type),
        .corr_out   (corr_out),
        .err_out    (err_out)
    );

    function automatic bit is_event(input logic [3:0] t);
        return (t == 4'h0) || (t == 4'h1);
    endfunction

    function automatic logic [CORR_W-1:0] model_corr(input logic [3:0] t,
            input logic [TS_W-1:0] ing, input logic [TS_W-1:0] egr,
            input logic [CORR_W-1:0] c);
        logic [CORR_W-1:0] res;
        if (is_event(t) && egr >= ing) begin
            res = CORR_W'(egr - ing);
            return c + (res << FRAC_BITS);
        end
        return c;
    endfunction

    function automatic string model_tag(input logic [3:0] t,
            input logic [TS_W-1:0] ing, input logic [TS_W-1:0] egr);
        if (is_event(t) && egr < ing) return "R7";
        case (t)
            4'h0: return "R2";
            4'h1: return "R3";
            4'h8: return "R4";
            4'h9: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [CORR_W-1:0] act, input logic [CORR_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        check(out_valid == e_v[1], "R8", "out_valid", 64'(out_valid), 64'(e_v[1]));
        if (e_v[1]) begin
            check(corr_out == e_c[1], e_tag[1], "corr_out", corr_out, e_c[1]);
            check(err_out == e_err[1], e_tag[1], "err_out", 64'(err_out), 64'(e_err[1]));
            check(out_type == e_t[1], "R9", "out_type", 64'(out_type), 64'(e_t[1]));
        end else begin
            check(corr_out == '0 && out_type == '0 && !err_out, "R10", "idle outputs",
                  {corr_out[59:0], out_type}, 64'd0);
        end
    endtask

    // one cycle: compare the result due now, then drive the next message
    task automatic step(input bit v, input logic [3:0] t, input logic [TS_W-1:0] ing,
                        input logic [TS_W-1:0] egr, input logic [CORR_W-1:0] c,
                        input string tag_override);
        @(negedge clk);
        compare_outputs();
        e_v[1] = e_v[0]; e_t[1] = e_t[0]; e_c[1] = e_c[0];
        e_err[1] = e_err[0]; e_tag[1] = e_tag[0];
        in_valid   = v;
        msg_type   = t;
        ingress_ts = ing;
        egress_ts  = egr;
        corr_in    = c;
        e_v[0]   = v;
        e_t[0]   = t;
        e_c[0]   = model_corr(t, ing, egr, c);
        e_err[0] = is_event(t) && (egr < ing);
        e_tag[0] = (tag_override != "") ? tag_override : model_tag(t, ing, egr);
    endtask

    task automatic idle();
        step(1'b0, 4'h0, '0, '0, '0, "");
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        logic [3:0]        t;
        logic [TS_W-1:0]   ing;
        logic [TS_W-1:0]   egr;
        logic [CORR_W-1:0] c;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 2; k++) begin
            e_v[k] = 1'b0; e_t[k] = '0; e_c[k] = '0; e_err[k] = 1'b0; e_tag[k] = "R8";
        end
        repeat (4) @(negedge clk);
        // R1: quiet during reset
        check(!out_valid && !err_out, "R1", "reset outputs", {62'd0, out_valid, err_out}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        check(!out_valid && !err_out, "R1", "after reset", {62'd0, out_valid, err_out}, 64'd0);
        idle();
        idle();

        // directed corners
        step(1'b1, 4'h0, 32'd1000, 32'd1000, 64'd77, "R7");          // equal: zero residence
        step(1'b1, 4'h0, 32'd1000, 32'd1001, 64'd0, "R2");           // one ns
        step(1'b1, 4'h1, 32'd0, 32'hFFFF_FFFF, 64'd5, "R3");         // max residence
        step(1'b1, 4'h0, 32'd10, 32'd9, 64'h1234, "R7");             // one ns late
        step(1'b1, 4'h1, 32'hFFFF_FFFF, 32'd0, 64'hABCD, "R7");
        step(1'b1, 4'h8, 32'd50, 32'd10, 64'hDEAD, "R4");            // late but follow-up
        step(1'b1, 4'h9, 32'd50, 32'd10, 64'hBEEF, "R5");
        step(1'b1, 4'h3, 32'd1, 32'd900, 64'h42, "R6");
        step(1'b1, 4'hF, 32'd1, 32'd900, 64'h43, "R6");
        step(1'b1, 4'h0, 32'd0, 32'd2, 64'h7FFF_FFFF_FFFF_FFFF, "R11"); // wraps negative
        step(1'b1, 4'h1, 32'd100, 32'd300, 64'hFFFF_FFFF_FFFF_0000, "R11"); // negative input
        idle();
        idle();

        // random traffic, mostly back to back
        for (int n = 0; n < 3000; n++) begin
            int sel;
            bit v;
            sel = $urandom % 6;
            case (sel)
                0: t = 4'h0;
                1: t = 4'h1;
                2: t = 4'h8;
                3: t = 4'h9;
                default: t = 4'($urandom);
            endcase
            ing = $urandom;
            case ($urandom % 8)
                0: egr = $urandom;
                1: egr = ing - TS_W'($urandom % 64);
                default: egr = ing + TS_W'($urandom % 200000);
            endcase
            c = {$urandom, $urandom};
            v = ($urandom % 4) != 0;
            step(v, t, ing, egr, c, "");
        end
        idle();
        idle();
        idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule